// File: doc/BRIEF.md
# Multilevel Redundant-State Switching Sequence Generator

This block turns the three corner vectors of the small triangle that holds the reference vector of a multilevel inverter into the four switching states applied during one sampling interval. Each corner arrives as a base per-phase state (one level code per phase) together with its alpha/beta coordinates. The corner nearest the true zero vector becomes the virtual zero. The sequence starts and ends on two redundant states of that virtual zero, and the other two corners fill the middle. Exactly one phase steps by one level at every transition.

A modulator upstream finds the triangle and the dwell times. It presents the corners, the level count and the interval parity, and pulses the sample strobe once per interval. The block registers the new sequence on that edge and holds it until the next strobe. Alternate intervals apply the same four states in reverse order, so the last state of one interval is the first state of the next. Data enters only on the strobe and the result is a held register, so there is no valid/ready handshake and the output cannot be stalled. The consumer reads the sequence at any time after the strobe.

Top module: `svseq_gen`

## Requirements
- R1: The virtual zero is the corner with the smallest |alpha| + |beta|. On a tie, the corner with the lowest index (0, 1, 2) wins.
- R2: The redundant states of a corner with base state s are s + k on all three phases, for k = 0 .. (N-1) - max(s). In a forward interval, position 0 holds the second-highest redundant state of the virtual zero and position 3 holds its highest.
- R3: Each of the other two corners appears in positions 1 and 2 as its highest redundant state, k = (N-1) - max(s).
- R4: The two non-zero corners are tried in index order first (lower index at position 1). If that order does not make each of the three forward transitions raise exactly one phase by one level with the other phases unchanged, the swapped order is used.
- R5: When odd_interval is 0 at the strobe, the forward order is loaded. When it is 1, the same four states are loaded in reverse, so position 0 holds the highest virtual-zero state.
- R6: seq_state, seq_valid and seq_err change only on a clock edge where sample_stb is 1, and show the new result one cycle after that edge. seq_valid is set by the first strobe after reset.
- R7: seq_err is 1 when N < 2, when any corner has a phase above N-1, when the virtual zero has fewer than two redundant states, or when neither middle order gives single-step transitions.
- R8: Level codes run from 0 to N-1, where N-1 is the positive rail; for N = 3, codes 2, 1 and 0 mean +Vdc/2, 0 and -Vdc/2. A state is 3*LW bits with phase a in the top LW bits and phase c in the bottom LW bits. Corner i sits at vtx_state[i*3*LW +: 3*LW], and sequence position j sits at seq_state[j*3*LW +: 3*LW].
- R9: While rst_n is low, seq_state is all zeros and seq_valid and seq_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Loads a new sequence on this edge |
| odd_interval | input | 1 | Interval parity: 0 forward, 1 reversed |
| n_levels | input | NW | Inverter level count N |
| vtx_state | input | 9*LW | Base states of corners 0..2 |
| vtx_alpha | input | 3*CW | Signed alpha coordinate of each corner |
| vtx_beta | input | 3*CW | Signed beta coordinate of each corner |
| seq_state | output | 12*LW | Four switching states, position 0 first |
| seq_valid | output | 1 | A sequence has been loaded since reset |
| seq_err | output | 1 | The loaded corners give no legal sequence |

## Verification
Random well-formed triangles are built from a lower state and a random pair of phase raises. They are placed in random corner slots with the virtual zero given the smallest offset, so both middle orders and both parities are exercised at level counts from 2 to 5. Random unstructured corners are added to reach the error paths. Directed cases cover a coordinate tie, which shows whether the lowest index wins, and a triangle that needs the swapped middle order. They also cover a virtual zero with a single redundant state, an out-of-range phase, and corners with no legal order, which separate the error causes. A hold test changes every input without a strobe, which shows whether the register updates outside the strobe.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
  localparam int PHASES = 3;
  localparam int SEQ_LEN = 4;
  localparam int CORNERS = 3;
endpackage

// File: rtl/svseq_vertex_expand.sv
module svseq_vertex_expand
  import svseq_pkg::*;
#(
  parameter int LW = 3,
  parameter int NW = 3
) (
  input  logic [PHASES*LW-1:0] base_st,
  input  logic [NW-1:0]        n_levels,
  output logic [PHASES*LW-1:0] top_st,
  output logic [PHASES*LW-1:0] sub_st,
  output logic                 multi_red,
  output logic                 in_range
);
  localparam int XW = ((LW > NW) ? LW : NW) + 1;

  logic [LW-1:0] max_ph;
  logic [XW-1:0] top_lvl, k_max;

  always_comb begin
    max_ph = base_st[LW-1:0];
    for (int p = 1; p < PHASES; p++)
      if (base_st[p*LW +: LW] > max_ph) max_ph = base_st[p*LW +: LW];
    top_lvl  = XW'(n_levels) - XW'(1);
    in_range = (n_levels >= NW'(2)) && (XW'(max_ph) <= top_lvl);
    k_max    = top_lvl - XW'(max_ph);
    multi_red = in_range && (k_max != '0);
    for (int p = 0; p < PHASES; p++) begin
      if (in_range) begin
        top_st[p*LW +: LW] = base_st[p*LW +: LW] + LW'(k_max);
        sub_st[p*LW +: LW] = multi_red ? top_st[p*LW +: LW] - LW'(1)
                                       : top_st[p*LW +: LW];
      end else begin
        top_st[p*LW +: LW] = base_st[p*LW +: LW];
        sub_st[p*LW +: LW] = base_st[p*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/svseq_vz_pick.sv
module svseq_vz_pick
  import svseq_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CORNERS*CW-1:0] alpha,
  input  logic [CORNERS*CW-1:0] beta,
  output logic [1:0]            vz_idx
);
  logic [CORNERS-1:0][CW+1:0] offs;

  for (genvar g = 0; g < CORNERS; g++) begin : g_off
    logic signed [CW:0] a_x, b_x;
    logic [CW:0] a_m, b_m;
    always_comb begin
      a_x = {alpha[g*CW+CW-1], alpha[g*CW +: CW]};
      b_x = {beta[g*CW+CW-1], beta[g*CW +: CW]};
      a_m = (a_x < 0) ? $unsigned(-a_x) : $unsigned(a_x);
      b_m = (b_x < 0) ? $unsigned(-b_x) : $unsigned(b_x);
      offs[g] = {1'b0, a_m} + {1'b0, b_m};
    end
  end

  always_comb begin
    vz_idx = 2'd0;
    if (offs[1] < offs[0]) vz_idx = 2'd1;
    if ((vz_idx == 2'd0 && offs[2] < offs[0]) ||
        (vz_idx == 2'd1 && offs[2] < offs[1])) vz_idx = 2'd2;
  end
endmodule

// File: rtl/svseq_order_pick.sv
module svseq_order_pick
  import svseq_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic [PHASES*LW-1:0] lo_st,
  input  logic [PHASES*LW-1:0] x_st,
  input  logic [PHASES*LW-1:0] y_st,
  input  logic [PHASES*LW-1:0] hi_st,
  output logic [PHASES*LW-1:0] mid0,
  output logic [PHASES*LW-1:0] mid1,
  output logic                 ord_ok
);
  function automatic logic one_up(input logic [PHASES*LW-1:0] a,
                                  input logic [PHASES*LW-1:0] b);
    int raised;
    logic others_same;
    raised = 0;
    others_same = 1'b1;
    for (int p = 0; p < PHASES; p++) begin
      if ({1'b0, b[p*LW +: LW]} == {1'b0, a[p*LW +: LW]} + (LW+1)'(1))
        raised++;
      else if (b[p*LW +: LW] != a[p*LW +: LW])
        others_same = 1'b0;
    end
    return others_same && (raised == 1);
  endfunction

  logic ok_a, ok_b;

  always_comb begin
    ok_a   = one_up(lo_st, x_st) && one_up(x_st, y_st) && one_up(y_st, hi_st);
    ok_b   = one_up(lo_st, y_st) && one_up(y_st, x_st) && one_up(x_st, hi_st);
    ord_ok = ok_a || ok_b;
    mid0   = (ok_a || !ok_b) ? x_st : y_st;
    mid1   = (ok_a || !ok_b) ? y_st : x_st;
  end
endmodule

// File: rtl/svseq_gen.sv
module svseq_gen
  import svseq_pkg::*;
#(
  parameter int MAX_LEVELS = 5,
  parameter int CW = 12,
  parameter int LW = $clog2(MAX_LEVELS),
  parameter int NW = $clog2(MAX_LEVELS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample_stb,
  input  logic                          odd_interval,
  input  logic [NW-1:0]                 n_levels,
  input  logic [CORNERS*PHASES*LW-1:0]  vtx_state,
  input  logic [CORNERS*CW-1:0]         vtx_alpha,
  input  logic [CORNERS*CW-1:0]         vtx_beta,
  output logic [SEQ_LEN*PHASES*LW-1:0]  seq_state,
  output logic                          seq_valid,
  output logic                          seq_err
);
  localparam int SW = PHASES * LW;

  logic [CORNERS-1:0][SW-1:0] top_st, sub_st;
  logic [CORNERS-1:0]         multi, inr;
  logic [1:0]                 vz_idx;
  logic [SW-1:0]              lo_st, hi_st, x_st, y_st, mid0, mid1;
  logic                       vz_multi, ord_ok, err_c;
  logic [SEQ_LEN*SW-1:0]      seq_c;

  for (genvar g = 0; g < CORNERS; g++) begin : g_vx
    svseq_vertex_expand #(.LW(LW), .NW(NW)) u_vx (
      .base_st  (vtx_state[g*SW +: SW]),
      .n_levels (n_levels),
      .top_st   (top_st[g]),
      .sub_st   (sub_st[g]),
      .multi_red(multi[g]),
      .in_range (inr[g])
    );
  end

  svseq_vz_pick #(.CW(CW)) u_vz (
    .alpha (vtx_alpha),
    .beta  (vtx_beta),
    .vz_idx(vz_idx)
  );

  always_comb begin
    case (vz_idx)
      2'd1: begin
        lo_st = sub_st[1]; hi_st = top_st[1]; vz_multi = multi[1];
        x_st = top_st[0]; y_st = top_st[2];
      end
      2'd2: begin
        lo_st = sub_st[2]; hi_st = top_st[2]; vz_multi = multi[2];
        x_st = top_st[0]; y_st = top_st[1];
      end
      default: begin
        lo_st = sub_st[0]; hi_st = top_st[0]; vz_multi = multi[0];
        x_st = top_st[1]; y_st = top_st[2];
      end
    endcase
  end

  svseq_order_pick #(.LW(LW)) u_ord (
    .lo_st (lo_st),
    .x_st  (x_st),
    .y_st  (y_st),
    .hi_st (hi_st),
    .mid0  (mid0),
    .mid1  (mid1),
    .ord_ok(ord_ok)
  );

  always_comb begin
    err_c = !(&inr) || !vz_multi || !ord_ok;
    seq_c = odd_interval ? {lo_st, mid0, mid1, hi_st}
                         : {hi_st, mid1, mid0, lo_st};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_state <= '0;
      seq_valid <= 1'b0;
      seq_err   <= 1'b0;
    end else if (sample_stb) begin
      seq_state <= seq_c;
      seq_valid <= 1'b1;
      seq_err   <= err_c;
    end
  end
endmodule

// File: rtl/svseq_gen_chk.sv
module svseq_gen_chk
  import svseq_pkg::*;
#(
  parameter int LW = 3,
  parameter int NW = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sample_stb,
  input logic [NW-1:0]                n_levels,
  input logic [SEQ_LEN*PHASES*LW-1:0] seq_state,
  input logic                         seq_valid,
  input logic                         seq_err
);
  localparam int SW = PHASES * LW;

  function automatic logic up1(input logic [SW-1:0] a, input logic [SW-1:0] b);
    int n_up, n_diff;
    n_up = 0;
    n_diff = 0;
    for (int p = 0; p < PHASES; p++) begin
      if ({1'b0, b[p*LW +: LW]} == {1'b0, a[p*LW +: LW]} + (LW+1)'(1)) n_up++;
      if (b[p*LW +: LW] != a[p*LW +: LW]) n_diff++;
    end
    return (n_up == 1) && (n_diff == 1);
  endfunction

  function automatic logic steps_ok(input logic [SEQ_LEN*SW-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < SEQ_LEN - 1; j++)
      ok = ok && (up1(s[j*SW +: SW], s[(j+1)*SW +: SW]) ||
                  up1(s[(j+1)*SW +: SW], s[j*SW +: SW]));
    return ok;
  endfunction

  function automatic logic bracket_ok(input logic [SEQ_LEN*SW-1:0] s);
    logic ok;
    logic [LW:0] f, l;
    ok = 1'b1;
    for (int p = 0; p < PHASES; p++) begin
      f = {1'b0, s[p*LW +: LW]};
      l = {1'b0, s[(SEQ_LEN-1)*SW + p*LW +: LW]};
      ok = ok && ((f == l + (LW+1)'(1)) || (l == f + (LW+1)'(1)));
    end
    return ok;
  endfunction

  function automatic logic codes_ok(input logic [SEQ_LEN*SW-1:0] s,
                                    input logic [NW-1:0] n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < SEQ_LEN * PHASES; i++)
      ok = ok && (32'(s[i*LW +: LW]) < 32'(n));
    return ok;
  endfunction

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(seq_state) && $stable(seq_valid) && $stable(seq_err));

  p_valid_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> seq_valid);

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !seq_err) |-> steps_ok(seq_state));

  p_vz_bracket_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !seq_err) |-> bracket_ok(seq_state));

  p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (seq_err || codes_ok(seq_state, $past(n_levels))));
endmodule

bind svseq_gen svseq_gen_chk #(.LW(LW), .NW(NW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_stb(sample_stb),
  .n_levels  (n_levels),
  .seq_state (seq_state),
  .seq_valid (seq_valid),
  .seq_err   (seq_err)
);

// File: tb/svseq_gen_tb.sv
module svseq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 3;
  localparam int NW = 3;
  localparam int CW = 12;
  localparam int SW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic odd_interval = 1'b0;
  logic [NW-1:0] n_levels = '0;
  logic [3*SW-1:0] vtx_state = '0;
  logic [3*CW-1:0] vtx_alpha = '0, vtx_beta = '0;
  logic [4*SW-1:0] seq_state;
  logic seq_valid, seq_err;

  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svseq_gen #(.MAX_LEVELS(5), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .odd_interval(odd_interval),
    .n_levels(n_levels), .vtx_state(vtx_state), .vtx_alpha(vtx_alpha),
    .vtx_beta(vtx_beta), .seq_state(seq_state), .seq_valid(seq_valid), .seq_err(seq_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pk(input int a, input int b, input int c);
    return {3'(a), 3'(b), 3'(c)};
  endfunction

  function automatic bit up1(input int a[3], input int b[3]);
    int n_up = 0, n_diff = 0;
    for (int p = 0; p < 3; p++) begin
      if (b[p] == a[p] + 1) n_up++;
      if (b[p] != a[p]) n_diff++;
    end
    return (n_up == 1) && (n_diff == 1);
  endfunction

  // Reference model built from R1..R8
  function automatic void model(input logic [3*SW-1:0] vs, input logic [3*CW-1:0] al,
                                input logic [3*CW-1:0] be, input int n, input bit par,
                                output logic [4*SW-1:0] seq, output bit err);
    int ph[3][3], tp[3][3], sb[3][3], k[3], off[3];
    bit inr[3];
    int vz, oa, ob, mx, a, b;
    int lo[3], hi[3], x[3], y[3], m0[3], m1[3];
    bit ok_a, ok_b;
    for (int v = 0; v < 3; v++) begin
      mx = 0;
      for (int p = 0; p < 3; p++) begin
        ph[v][p] = int'(vs[v*SW + (2-p)*LW +: LW]);
        if (ph[v][p] > mx) mx = ph[v][p];
      end
      inr[v] = (n >= 2) && (mx <= n - 1);
      k[v] = n - 1 - mx;
      for (int p = 0; p < 3; p++) begin
        tp[v][p] = inr[v] ? ph[v][p] + k[v] : ph[v][p];
        sb[v][p] = (inr[v] && k[v] >= 1) ? tp[v][p] - 1 : tp[v][p];
      end
      a = int'($signed(al[v*CW +: CW]));
      b = int'($signed(be[v*CW +: CW]));
      off[v] = (a < 0 ? -a : a) + (b < 0 ? -b : b);
    end
    vz = 0;
    if (off[1] < off[vz]) vz = 1;
    if (off[2] < off[vz]) vz = 2;
    oa = (vz == 0) ? 1 : 0;
    ob = (vz == 2) ? 1 : 2;
    lo = sb[vz]; hi = tp[vz]; x = tp[oa]; y = tp[ob];
    ok_a = up1(lo, x) && up1(x, y) && up1(y, hi);
    ok_b = up1(lo, y) && up1(y, x) && up1(x, hi);
    if (ok_a || !ok_b) begin m0 = x; m1 = y; end
    else begin m0 = y; m1 = x; end
    err = !(inr[0] && inr[1] && inr[2]) || !(k[vz] >= 1) || !(ok_a || ok_b);
    if (!par)
      seq = {pk(hi[0],hi[1],hi[2]), pk(m1[0],m1[1],m1[2]),
             pk(m0[0],m0[1],m0[2]), pk(lo[0],lo[1],lo[2])};
    else
      seq = {pk(lo[0],lo[1],lo[2]), pk(m0[0],m0[1],m0[2]),
             pk(m1[0],m1[1],m1[2]), pk(hi[0],hi[1],hi[2])};
  endfunction

  task automatic strobe(input logic [3*SW-1:0] vs, input logic [3*CW-1:0] al,
                        input logic [3*CW-1:0] be, input int n, input bit par);
    @(negedge clk);
    vtx_state = vs; vtx_alpha = al; vtx_beta = be;
    n_levels = NW'(n); odd_interval = par; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic run_model(input string tag, input logic [3*SW-1:0] vs,
                           input logic [3*CW-1:0] al, input logic [3*CW-1:0] be,
                           input int n, input bit par);
    logic [4*SW-1:0] e_seq;
    bit e_err;
    model(vs, al, be, n, par, e_seq, e_err);
    strobe(vs, al, be, n, par);
    chk({tag, " err R7"}, 64'(seq_err), 64'(e_err));
    if (!e_err) chk({tag, " seq"}, 64'(seq_state), 64'(e_seq));
  endtask

  function automatic logic [CW-1:0] c12(input int v);
    return CW'(v);
  endfunction

  task automatic gen_geom(output logic [3*SW-1:0] vs, output logic [3*CW-1:0] al,
                          output logic [3*CW-1:0] be, output int n);
    int s[3], x[3], y[3], p0, p1, mn, slot_vz, slot_x, slot_y;
    logic [SW-1:0] st[3];
    n = 2 + int'($urandom_range(3));
    for (int p = 0; p < 3; p++) s[p] = int'($urandom_range(n - 2));
    p0 = int'($urandom_range(2));
    p1 = (p0 + 1 + int'($urandom_range(1))) % 3;
    x = s; x[p0]++;
    y = x; y[p1]++;
    mn = s[0]; for (int p = 1; p < 3; p++) if (s[p] < mn) mn = s[p];
    st[0] = pk(s[0]-mn, s[1]-mn, s[2]-mn);
    mn = x[0]; for (int p = 1; p < 3; p++) if (x[p] < mn) mn = x[p];
    st[1] = pk(x[0]-mn, x[1]-mn, x[2]-mn);
    mn = y[0]; for (int p = 1; p < 3; p++) if (y[p] < mn) mn = y[p];
    st[2] = pk(y[0]-mn, y[1]-mn, y[2]-mn);
    slot_vz = int'($urandom_range(2));
    slot_x = (slot_vz + 1 + int'($urandom_range(1))) % 3;
    slot_y = 3 - slot_vz - slot_x;
    vs = '0; al = '0; be = '0;
    vs[slot_vz*SW +: SW] = st[0];
    vs[slot_x*SW +: SW] = st[1];
    vs[slot_y*SW +: SW] = st[2];
    for (int v = 0; v < 3; v++) begin
      int m = (v == slot_vz) ? 40 : 600;
      int base = (v == slot_vz) ? 0 : 200;
      int sa = ($urandom_range(1) != 0) ? 1 : -1;
      int sbg = ($urandom_range(1) != 0) ? 1 : -1;
      al[v*CW +: CW] = c12(sa * (base + int'($urandom_range(m))));
      be[v*CW +: CW] = c12(sbg * (base + int'($urandom_range(m))));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [3*SW-1:0] vs;
    logic [3*CW-1:0] al, be;
    logic [4*SW-1:0] held;
    int n;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk("R9 reset seq", 64'(seq_state), 64'd0);
    chk("R9 reset valid", 64'(seq_valid), 64'd0);
    chk("R9 reset err", 64'(seq_err), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 valid before strobe", 64'(seq_valid), 64'd0);

    // R2 R3 R8: corners 310, 320, vz 210 at slot 2, N=5 -> 321-421-431-432
    vs = {pk(2,1,0), pk(3,2,0), pk(3,1,0)};
    al = {c12(5), c12(-400), c12(300)};
    be = {c12(-5), c12(0), c12(0)};
    strobe(vs, al, be, 5, 1'b0);
    chk("R6 valid after strobe", 64'(seq_valid), 64'd1);
    chk("R2 R3 R8 forward seq", 64'(seq_state),
        64'({pk(4,3,2), pk(4,3,1), pk(4,2,1), pk(3,2,1)}));
    chk("R7 no error", 64'(seq_err), 64'd0);

    // R5: same corners, odd interval -> reversed
    strobe(vs, al, be, 5, 1'b1);
    chk("R5 reverse seq", 64'(seq_state),
        64'({pk(3,2,1), pk(4,2,1), pk(4,3,1), pk(4,3,2)}));

    // R6: inputs change without strobe, output must hold
    held = seq_state;
    @(negedge clk);
    vtx_state = {pk(0,0,0), pk(1,1,1), pk(2,0,0)};
    n_levels = NW'(3); odd_interval = 1'b0;
    vtx_alpha = '0; vtx_beta = '0;
    repeat (5) @(negedge clk);
    chk("R6 hold without strobe", 64'(seq_state), 64'(held));
    chk("R6 err hold", 64'(seq_err), 64'd0);

    // R4: N=3, vz 110 at slot 2, index order fails -> 110-210-211-221
    vs = {pk(1,1,0), pk(2,1,0), pk(1,0,0)};
    al = {c12(5), c12(60), c12(50)};
    be = '0;
    strobe(vs, al, be, 3, 1'b0);
    chk("R4 swapped middle", 64'(seq_state),
        64'({pk(2,2,1), pk(2,1,1), pk(2,1,0), pk(1,1,0)}));
    chk("R4 err", 64'(seq_err), 64'd0);

    // R1: tie between slot 0 (210) and slot 2 (320), lowest index wins
    vs = {pk(3,2,0), pk(3,1,0), pk(2,1,0)};
    al = {c12(-10), c12(100), c12(10)};
    be = '0;
    strobe(vs, al, be, 5, 1'b0);
    chk("R1 tie lowest index", 64'(seq_state),
        64'({pk(4,3,2), pk(4,3,1), pk(4,2,1), pk(3,2,1)}));

    // R7: virtual zero 420 has one redundant state at N=5
    vs = {pk(4,3,0), pk(4,3,1), pk(4,2,0)};
    al = {c12(300), c12(300), c12(1)};
    be = '0;
    strobe(vs, al, be, 5, 1'b0);
    chk("R7 single-state virtual zero", 64'(seq_err), 64'd1);

    // R7: phase above N-1
    vs = {pk(1,0,0), pk(3,0,0), pk(1,1,0)};
    al = {c12(200), c12(200), c12(0)};
    strobe(vs, al, be, 3, 1'b0);
    chk("R7 out of range phase", 64'(seq_err), 64'd1);

    // R7: no legal middle order
    vs = {pk(0,0,0), pk(0,0,0), pk(2,1,0)};
    al = {c12(300), c12(300), c12(2)};
    strobe(vs, al, be, 5, 1'b0);
    chk("R7 no legal order", 64'(seq_err), 64'd1);

    // Random geometric triangles: R1 R2 R3 R4 R5
    for (int t = 0; t < 400; t++) begin
      gen_geom(vs, al, be, n);
      run_model("R1/R2/R3/R4/R5 random", vs, al, be, n, t[0]);
    end

    // Random unstructured corners: R7
    for (int t = 0; t < 200; t++) begin
      vs = '0;
      for (int i = 0; i < 9; i++) vs[i*LW +: LW] = LW'($urandom_range(5));
      for (int v = 0; v < 3; v++) begin
        al[v*CW +: CW] = c12(int'($urandom_range(400)) - 200);
        be[v*CW +: CW] = c12(int'($urandom_range(400)) - 200);
      end
      run_model("R7 random", vs, al, be, 2 + int'($urandom_range(3)), t[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule